// File: doc/BRIEF.md
# Binary64 Result Rounding Stage

This block is the last step of a double-precision arithmetic datapath. An adder, multiplier or fused multiply-add core hands it an unrounded result: a sign, an unbiased exponent with enough headroom for results far above or below the representable range, a normalized 53-bit significand, and a guard and a sticky bit for everything below it. The stage applies the selected rounding direction and shifts tiny results into the subnormal range. It clamps results that are too large to either infinity or the largest finite value, as the direction requires. It returns the packed 64-bit word together with overflow, underflow and inexact flags. NaN and infinity operands never come through here. They take a separate bypass path.

Results arrive on a valid/ready input and leave on a valid/ready output through one register stage. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stream with `out_ready` held high moves one result per cycle. While `out_valid` is high and `out_ready` is low, the output word and flags are frozen and no new input is taken. The rounding direction travels with each result on `in_rmode`.

Top module: `fpr_round_stage`

## Requirements
- R1: An input taken on a clock edge where `in_valid` and `in_ready` are both high appears on the outputs with `out_valid` high after that edge. `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. After reset `out_valid` is low and `in_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bits` and the three flags hold their values.
- R3: `in_rmode` codes are 0 nearest-even, 1 toward zero, 2 toward plus infinity and 3 toward minus infinity. In nearest-even mode the stage adds one unit in the last place exactly when guard is 1 and either sticky or the kept LSB is 1.
- R4: Toward zero always truncates. Toward plus infinity adds one unit to a positive inexact result and truncates a negative one. Toward minus infinity does the reverse.
- R5: A rounding carry out of an all-ones fraction increments the exponent field and clears the fraction.
- R6: A result whose biased exponent reaches 2047, before or after rounding, is an overflow. It becomes infinity in nearest-even mode and in the direction that points away from zero for its sign. Otherwise it becomes the largest finite magnitude 0x7FEFFFFFFFFFFFFF with the sign kept. Overflow and inexact are both raised.
- R7: A result whose biased exponent is 0 or below is tiny. It is shifted right into the subnormal field, and every bit shifted out is added to the sticky bit. If it is also inexact, underflow and inexact are both raised. The square of the smallest normal value gives zero in every mode except the one pointing away from zero for its sign, where it gives encoding 1.
- R8: A tiny result that is exact is returned as a subnormal with no flags. For example, exponent -1074 with significand 1.0 gives encoding 0x1.
- R9: A zero significand gives a zero with the input sign and no flags.
- R10: Inexact is raised whenever the guard or sticky bit left after denormalization is nonzero. `out_bits` is packed as sign at bit 63, exponent field in bits 62:52 and fraction in bits 51:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Unrounded result present |
| in_ready | output | 1 | Stage can take a result this cycle |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | EXP_W (13) | Unbiased exponent, two's complement |
| in_sig | input | FRAC_W+1 (53) | Significand, leading one at the top bit, or all zero |
| in_guard | input | 1 | First bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| in_rmode | input | 2 | Rounding direction code |
| out_valid | output | 1 | Rounded result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_bits | output | EXP_BITS+FRAC_W+1 (64) | Packed binary64 result |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The bench builds the stage with its default parameters: a 13-bit input exponent, an 11-bit exponent field and a 52-bit fraction. The exponent width reaches -2044, the exponent of the smallest normal value squared, so the denormalizing shift hits its cap and the whole significand collapses into sticky. It also reaches +1024, so overflow is entered directly as well as through a rounding carry from 1023. The full-width fraction lets the all-ones carry, the subnormal-to-normal carry and the exact single-bit subnormal be driven at their real binary64 encodings.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
  } fflags_t;
endpackage

// File: rtl/fpr_align.sv
// Biases the exponent, flags too-large and tiny results, and shifts tiny
// significands right into the subnormal field while collecting lost bits.
module fpr_align #(
  parameter int EXP_W    = 13,
  parameter int EXP_BITS = 11,
  parameter int FRAC_W   = 52
) (
  input  logic [EXP_W-1:0]    exp_i,
  input  logic [FRAC_W:0]     sig_i,
  input  logic                guard_i,
  input  logic                sticky_i,
  output logic [EXP_BITS-1:0] field_o,
  output logic [FRAC_W-1:0]   frac_o,
  output logic                guard_o,
  output logic                sticky_o,
  output logic                tiny_o,
  output logic                huge_o
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_BITS - 1)) - 1;
  localparam int EMAX   = (1 << EXP_BITS) - 1;
  localparam int SH_CAP = FRAC_W + 2;
  localparam int SH_W   = $clog2(SH_CAP + 1);
  localparam int D      = SIG_W + 1 + SH_CAP;
  localparam int BW     = EXP_W + 2;

  logic signed [BW-1:0] biased;
  logic signed [BW-1:0] deficit;
  logic [SH_W-1:0]      sh;
  logic [D-1:0]         vec;
  logic [D-1:0]         shv;

  always_comb begin
    biased  = $signed({{2{exp_i[EXP_W-1]}}, exp_i}) + $signed(BW'(BIAS));
    huge_o  = biased >= $signed(BW'(EMAX));
    tiny_o  = biased < $signed(BW'(1));
    deficit = $signed(BW'(1)) - biased;
    if (!tiny_o)                             sh = '0;
    else if (deficit > $signed(BW'(SH_CAP))) sh = SH_W'(SH_CAP);
    else                                     sh = deficit[SH_W-1:0];
    vec      = {sig_i, guard_i, {SH_CAP{1'b0}}};
    shv      = vec >> sh;
    // the leading one survives only for a normal result
    field_o  = shv[D-1] ? biased[EXP_BITS-1:0] : '0;
    frac_o   = shv[D-2 -: FRAC_W];
    guard_o  = shv[D-SIG_W-1];
    sticky_o = sticky_i | (|shv[D-SIG_W-2:0]);
  end
endmodule

// File: rtl/fpr_rinc.sv
// Decides whether one unit in the last place is added.
module fpr_rinc
  import fpr_pkg::*;
(
  input  rmode_e rmode_i,
  input  logic   sign_i,
  input  logic   lsb_i,
  input  logic   guard_i,
  input  logic   sticky_i,
  output logic   inc_o,
  output logic   inexact_o
);
  always_comb begin
    inexact_o = guard_i | sticky_i;
    unique case (rmode_i)
      RM_NEAR: inc_o = guard_i & (sticky_i | lsb_i);
      RM_ZERO: inc_o = 1'b0;
      RM_UP:   inc_o = ~sign_i & inexact_o;
      RM_DOWN: inc_o = sign_i & inexact_o;
    endcase
  end
endmodule

// File: rtl/fpr_pack.sv
// Adds the increment across exponent and fraction, then applies overflow
// saturation, the zero case and the flag rules.
module fpr_pack
  import fpr_pkg::*;
#(
  parameter int EXP_BITS = 11,
  parameter int FRAC_W   = 52
) (
  input  rmode_e                     rmode_i,
  input  logic                       sign_i,
  input  logic                       zero_i,
  input  logic                       tiny_i,
  input  logic                       huge_i,
  input  logic [EXP_BITS-1:0]        field_i,
  input  logic [FRAC_W-1:0]          frac_i,
  input  logic                       inc_i,
  input  logic                       inexact_i,
  output logic [EXP_BITS+FRAC_W:0]   bits_o,
  output fflags_t                    flags_o
);
  localparam int MW = EXP_BITS + FRAC_W;

  logic [MW-1:0] sum;
  logic [MW-1:0] sat_mag;
  logic          ovf;
  logic          to_inf;

  always_comb begin
    sum    = {field_i, frac_i} + MW'(inc_i);
    ovf    = ~zero_i & (huge_i | (&sum[MW-1 -: EXP_BITS]));
    to_inf = (rmode_i == RM_NEAR) |
             ((rmode_i == RM_UP) & ~sign_i) |
             ((rmode_i == RM_DOWN) & sign_i);
    sat_mag = to_inf ? {{EXP_BITS{1'b1}}, {FRAC_W{1'b0}}}
                     : {{(EXP_BITS-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    if (zero_i)   bits_o = {sign_i, {MW{1'b0}}};
    else if (ovf) bits_o = {sign_i, sat_mag};
    else          bits_o = {sign_i, sum};
    flags_o.ovf = ovf;
    flags_o.unf = ~zero_i & ~ovf & tiny_i & inexact_i;
    flags_o.inx = ~zero_i & (inexact_i | ovf);
  end
endmodule

// File: rtl/fpr_round_stage.sv
module fpr_round_stage
  import fpr_pkg::*;
#(
  parameter int EXP_W    = 13,
  parameter int EXP_BITS = 11,
  parameter int FRAC_W   = 52
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_sign,
  input  logic [EXP_W-1:0]         in_exp,
  input  logic [FRAC_W:0]          in_sig,
  input  logic                     in_guard,
  input  logic                     in_sticky,
  input  logic [1:0]               in_rmode,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [EXP_BITS+FRAC_W:0] out_bits,
  output logic                     out_overflow,
  output logic                     out_underflow,
  output logic                     out_inexact
);
  localparam int WW = EXP_BITS + FRAC_W + 1;

  rmode_e                rm;
  logic                  zero;
  logic [EXP_BITS-1:0]   field;
  logic [FRAC_W-1:0]     frac;
  logic                  g_al, s_al, tiny, huge;
  logic                  inc, inexact;
  logic [WW-1:0]         bits_nx;
  fflags_t               flags_nx;

  assign rm       = rmode_e'(in_rmode);
  assign zero     = ~|in_sig;
  assign in_ready = ~out_valid | out_ready;

  fpr_align #(.EXP_W(EXP_W), .EXP_BITS(EXP_BITS), .FRAC_W(FRAC_W)) align_i (
    .exp_i(in_exp), .sig_i(in_sig), .guard_i(in_guard), .sticky_i(in_sticky),
    .field_o(field), .frac_o(frac), .guard_o(g_al), .sticky_o(s_al),
    .tiny_o(tiny), .huge_o(huge)
  );

  fpr_rinc rinc_i (
    .rmode_i(rm), .sign_i(in_sign), .lsb_i(frac[0]), .guard_i(g_al),
    .sticky_i(s_al), .inc_o(inc), .inexact_o(inexact)
  );

  fpr_pack #(.EXP_BITS(EXP_BITS), .FRAC_W(FRAC_W)) pack_i (
    .rmode_i(rm), .sign_i(in_sign), .zero_i(zero), .tiny_i(tiny),
    .huge_i(huge), .field_i(field), .frac_i(frac), .inc_i(inc),
    .inexact_i(inexact), .bits_o(bits_nx), .flags_o(flags_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_bits      <= '0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
      out_inexact   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid     <= 1'b1;
      out_bits      <= bits_nx;
      out_overflow  <= flags_nx.ovf;
      out_underflow <= flags_nx.unf;
      out_inexact   <= flags_nx.inx;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fpr_round_stage_chk.sv
module fpr_round_stage_chk #(
  parameter int EXP_BITS = 11,
  parameter int FRAC_W   = 52
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [EXP_BITS+FRAC_W:0] out_bits,
  input logic                     out_overflow,
  input logic                     out_underflow,
  input logic                     out_inexact
);
  localparam logic [EXP_BITS+FRAC_W-1:0] INF_MAG =
    {{EXP_BITS{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [EXP_BITS+FRAC_W-1:0] MAX_MAG =
    {{(EXP_BITS-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R1
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bits) &&
      $stable(out_overflow) && $stable(out_underflow) && $stable(out_inexact));
  // R6
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_inexact);
  // R6
  ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |->
      (out_bits[EXP_BITS+FRAC_W-1:0] == INF_MAG) ||
      (out_bits[EXP_BITS+FRAC_W-1:0] == MAX_MAG));
  // R7
  unf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_underflow |-> out_inexact && !out_overflow);
endmodule

bind fpr_round_stage fpr_round_stage_chk #(.EXP_BITS(EXP_BITS), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
  .out_overflow(out_overflow), .out_underflow(out_underflow),
  .out_inexact(out_inexact)
);

// File: tb/fpr_round_stage_tb_top.sv
`timescale 1ns/1ps
module fpr_round_stage_tb_top;
  localparam logic [52:0] ONE  = 53'h10000000000000;
  localparam logic [52:0] ALL1 = 53'h1FFFFFFFFFFFFF;

  typedef struct packed {
    logic        sgn;
    logic [12:0] ex;
    logic [52:0] sig;
    logic        g;
    logic        s;
    logic [1:0]  rm;
    logic [63:0] res;
    logic [2:0]  fl;   // {overflow, underflow, inexact}
  } vec_t;

  localparam int NV = 30;
  // exponents: 13'h1804 = -2044, 13'h1BCE = -1074, 13'h1C01 = -1023, 13'h1C02 = -1022
  localparam vec_t VECS [NV] = '{
    '{1'b0, 13'h0000, ONE | 53'd2, 1'b0, 1'b1, 2'd0, 64'h3FF0000000000002, 3'b001},
    '{1'b0, 13'h0000, ONE | 53'd2, 1'b0, 1'b1, 2'd1, 64'h3FF0000000000002, 3'b001},
    '{1'b0, 13'h0000, ONE | 53'd2, 1'b0, 1'b1, 2'd2, 64'h3FF0000000000003, 3'b001},
    '{1'b0, 13'h0000, ONE | 53'd2, 1'b0, 1'b1, 2'd3, 64'h3FF0000000000002, 3'b001},
    '{1'b0, 13'h0400, ONE, 1'b0, 1'b0, 2'd0, 64'h7FF0000000000000, 3'b101},
    '{1'b0, 13'h0400, ONE, 1'b0, 1'b0, 2'd1, 64'h7FEFFFFFFFFFFFFF, 3'b101},
    '{1'b0, 13'h0400, ONE, 1'b0, 1'b0, 2'd2, 64'h7FF0000000000000, 3'b101},
    '{1'b0, 13'h0400, ONE, 1'b0, 1'b0, 2'd3, 64'h7FEFFFFFFFFFFFFF, 3'b101},
    '{1'b1, 13'h0400, ONE, 1'b0, 1'b0, 2'd2, 64'hFFEFFFFFFFFFFFFF, 3'b101},
    '{1'b1, 13'h0400, ONE, 1'b0, 1'b0, 2'd3, 64'hFFF0000000000000, 3'b101},
    '{1'b1, 13'h0400, ONE, 1'b0, 1'b0, 2'd0, 64'hFFF0000000000000, 3'b101},
    '{1'b0, 13'h03FF, ALL1, 1'b1, 1'b0, 2'd0, 64'h7FF0000000000000, 3'b101},
    '{1'b0, 13'h03FF, ALL1, 1'b1, 1'b0, 2'd1, 64'h7FEFFFFFFFFFFFFF, 3'b001},
    '{1'b0, 13'h0000, ALL1, 1'b1, 1'b0, 2'd0, 64'h4000000000000000, 3'b001},
    '{1'b0, 13'h0000, ONE, 1'b1, 1'b0, 2'd0, 64'h3FF0000000000000, 3'b001},
    '{1'b0, 13'h0000, ONE | 53'd1, 1'b1, 1'b0, 2'd0, 64'h3FF0000000000002, 3'b001},
    '{1'b0, 13'h0000, ONE | 53'd1, 1'b0, 1'b1, 2'd0, 64'h3FF0000000000001, 3'b001},
    '{1'b0, 13'h1804, ONE, 1'b0, 1'b0, 2'd0, 64'h0000000000000000, 3'b011},
    '{1'b0, 13'h1804, ONE, 1'b0, 1'b0, 2'd1, 64'h0000000000000000, 3'b011},
    '{1'b0, 13'h1804, ONE, 1'b0, 1'b0, 2'd2, 64'h0000000000000001, 3'b011},
    '{1'b0, 13'h1804, ONE, 1'b0, 1'b0, 2'd3, 64'h0000000000000000, 3'b011},
    '{1'b1, 13'h1804, ONE, 1'b0, 1'b0, 2'd3, 64'h8000000000000001, 3'b011},
    '{1'b1, 13'h1804, ONE, 1'b0, 1'b0, 2'd2, 64'h8000000000000000, 3'b011},
    '{1'b0, 13'h1BCE, ONE, 1'b0, 1'b0, 2'd2, 64'h0000000000000001, 3'b000},
    '{1'b0, 13'h1C01, ALL1, 1'b0, 1'b0, 2'd0, 64'h0010000000000000, 3'b011},
    '{1'b0, 13'h1C01, ALL1, 1'b0, 1'b0, 2'd1, 64'h000FFFFFFFFFFFFF, 3'b011},
    '{1'b0, 13'h1C02, ONE, 1'b0, 1'b0, 2'd2, 64'h0010000000000000, 3'b000},
    '{1'b1, 13'h0000, 53'd0, 1'b0, 1'b0, 2'd0, 64'h8000000000000000, 3'b000},
    '{1'b1, 13'h0000, ONE | 53'd1, 1'b0, 1'b1, 2'd3, 64'hBFF0000000000002, 3'b001},
    '{1'b1, 13'h0000, ONE | 53'd1, 1'b0, 1'b1, 2'd2, 64'hBFF0000000000001, 3'b001}
  };
  // requirement tag per table row
  localparam string TAGS [NV] = '{
    "R3", "R4", "R4", "R4", "R6", "R6", "R6", "R6", "R6", "R6",
    "R6", "R5", "R10", "R5", "R3", "R3", "R3", "R7", "R7", "R7",
    "R7", "R7", "R7", "R8", "R7", "R7", "R8", "R9", "R4", "R4"
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [12:0] in_exp = '0;
  logic [52:0] in_sig = '0;
  logic        in_guard = 1'b0;
  logic        in_sticky = 1'b0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_bits;
  logic        out_overflow, out_underflow, out_inexact;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpr_round_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_guard(in_guard),
    .in_sticky(in_sticky), .in_rmode(in_rmode), .out_valid(out_valid),
    .out_ready(out_ready), .out_bits(out_bits), .out_overflow(out_overflow),
    .out_underflow(out_underflow), .out_inexact(out_inexact)
  );

  task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_sign = v.sgn; in_exp = v.ex; in_sig = v.sig;
    in_guard = v.g; in_sticky = v.s; in_rmode = v.rm;
    in_valid = 1'b1;
  endtask

  function automatic logic [67:0] got();
    return {out_valid, out_bits, out_overflow, out_underflow, out_inexact};
  endfunction

  initial begin
    // R11-style reset state is part of R1
    #5;
    check("R1 reset", {66'd0, out_valid, in_ready}, {66'd0, 1'b0, 1'b1});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {66'd0, out_valid, in_ready}, {66'd0, 1'b0, 1'b1});

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check(TAGS[i], got(), {1'b1, VECS[i].res, VECS[i].fl});
    end
    @(negedge clk);
    check("R1 drain", {67'd0, out_valid}, 68'd0);

    // R2 stall: hold out_ready low, offer a second result meanwhile
    out_ready = 1'b0;
    drive(VECS[4]);
    @(negedge clk);
    check("R1 stall ready", {66'd0, out_valid, in_ready}, {66'd0, 1'b1, 1'b0});
    drive(VECS[19]);
    repeat (3) @(negedge clk);
    check("R2 hold", got(), {1'b1, VECS[4].res, VECS[4].fl});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 release", got(), {1'b1, VECS[19].res, VECS[19].fl});

    // R1 back-to-back stream
    drive(VECS[0]);
    @(negedge clk);
    check("R1 stream a", got(), {1'b1, VECS[0].res, VECS[0].fl});
    drive(VECS[13]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 stream b", got(), {1'b1, VECS[13].res, VECS[13].fl});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule